// File: doc/BRIEF.md
# Tri-Level PWM Gate Sequencer

This block is the digital control path for one phase of a synchronous buck gate driver. Two digitized comparator outputs classify a three-level PWM input as high, mid or low. A high level calls for the high-side switch. A low level calls for the low-side switch. At the mid level the block emulates a diode: the low-side switch stays on while the inductor current is positive, and both switches are off once the current reverses.

Every turn-on is guarded by adaptive dead time. A gate is commanded on only after three things have happened: the opposite gate command has been dropped, the opposite gate's off-sense flag has been seen, and a dead-time counter has run out. A supervisor can force the low-side switch on. Dropping chip-enable masks both outputs at once, with no clock edge needed.

All asynchronous inputs pass through two flip-flops before use, and chip-enable is the exception only for the output mask.

Top module: `tlpwm_gate_seq`

## Requirements
- R1: Comparator code {cmp_above_hi, cmp_above_lo} = 2'b11 (high level) settles to hs_gate=1, ls_gate=0, whatever i_rev is.
- R2: Code 2'b00 (low level) settles to hs_gate=0, ls_gate=1.
- R3: Code 2'b01 (mid level) with i_rev=0 (positive current) settles to hs_gate=0, ls_gate=1.
- R4: Code 2'b01 with i_rev=1 (reversed current) settles to both gates off.
- R5: The invalid code 2'b10 behaves exactly like the mid code 2'b01.
- R6: On a low-to-high PWM change, ls_gate drops first. hs_gate rises only once ls_gate is low, ls_off_sns has passed the synchronizer, and DEAD_CYC further cycles have elapsed. With an off-sense that follows the gate directly, hs_gate rises on the (6+DEAD_CYC)-th rising clock edge after the input change. While ls_off_sns stays 0, hs_gate stays 0.
- R7: On a high-to-low PWM change, hs_gate drops first. ls_gate rises with the same rule mirrored, again on the (6+DEAD_CYC)-th edge.
- R8: chip_en=0 forces both outputs low in the same cycle, without waiting for a clock edge. After chip_en returns to 1 with a high PWM level, hs_gate rises on the (4+DEAD_CYC)-th edge.
- R9: force_ls=1 settles to ls_gate=1 and hs_gate=0 for any PWM code and any current direction.
- R10: hs_gate and ls_gate are never 1 together.
- R11: Each new target restarts the dead-time count from zero. If PWM reverses to low before a pending high-side turn-on, hs_gate never rises, and ls_gate rises on the (4+DEAD_CYC)-th edge after the reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip enable; 0 masks both gates immediately |
| cmp_above_hi | input | 1 | PWM above upper threshold |
| cmp_above_lo | input | 1 | PWM above lower threshold |
| i_rev | input | 1 | 1 when inductor current is reversed |
| force_ls | input | 1 | Supervisor request to hold the low-side gate on |
| hs_off_sns | input | 1 | High-side gate sensed off |
| ls_off_sns | input | 1 | Low-side gate sensed off |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
Each input change takes two edges to cross the synchronizer and one more edge to reach the target register. A gate that is already on therefore drops on the third edge. Waiting for the opposite gate's off-sense adds two edges, and the counter adds DEAD_CYC+1 more, so a turn-on lands on edge 6+DEAD_CYC, or 4+DEAD_CYC when the off-sense is already present. The bench drives inputs at falling edges and counts rising edges, sampling at each falling edge, so these exact figures are checked. The stimulus table waits far longer than the worst case before it checks the settled gate pair.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;

  typedef enum logic [1:0] {LVL_LOW = 2'd0, LVL_MID = 2'd1, LVL_HIGH = 2'd2} pwm_lvl_e;
  typedef enum logic [1:0] {TGT_OFF = 2'd0, TGT_HS = 2'd1, TGT_LS = 2'd2} gate_tgt_e;

  // index of each signal in the synchronizer bank
  localparam int SI_HI    = 0;
  localparam int SI_LO    = 1;
  localparam int SI_REV   = 2;
  localparam int SI_FORCE = 3;
  localparam int SI_HSOFF = 4;
  localparam int SI_LSOFF = 5;
  localparam int SI_EN    = 6;
  localparam int SI_NUM   = 7;

  // code {above_hi, above_lo}; 2'b10 cannot occur legally and is read as mid
  function automatic pwm_lvl_e classify(input logic [1:0] code);
    case (code)
      2'b11:   return LVL_HIGH;
      2'b00:   return LVL_LOW;
      default: return LVL_MID;
    endcase
  endfunction

  function automatic gate_tgt_e pick_target(input pwm_lvl_e lvl, input logic rev,
                                            input logic force_low);
    if (force_low) return TGT_LS;
    case (lvl)
      LVL_HIGH: return TGT_HS;
      LVL_LOW:  return TGT_LS;
      default:  return rev ? TGT_OFF : TGT_LS;
    endcase
  endfunction

endpackage

// File: rtl/tlpwm_sync.sv
module tlpwm_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg1;
  logic [W-1:0] stg2;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg1[g] <= 1'b0;
        stg2[g] <= 1'b0;
      end else begin
        stg1[g] <= d_async[g];
        stg2[g] <= stg1[g];
      end
    end
  end

  assign d_sync = stg2;
endmodule

// File: rtl/tlpwm_decode.sv
module tlpwm_decode
  import tlpwm_pkg::*;
(
  input  logic      above_hi,
  input  logic      above_lo,
  input  logic      rev,
  input  logic      force_low,
  output pwm_lvl_e  lvl,
  output gate_tgt_e target
);
  always_comb begin
    lvl    = classify({above_hi, above_lo});
    target = pick_target(lvl, rev, force_low);
  end
endmodule

// File: rtl/tlpwm_deadtime.sv
module tlpwm_deadtime
  import tlpwm_pkg::*;
#(
  parameter int DEAD_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_s,
  input  gate_tgt_e target,
  input  logic      hs_off_s,
  input  logic      ls_off_s,
  output logic      hs_q,
  output logic      ls_q
);
  localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_W = CW'(DEAD_CYC);

  gate_tgt_e    tgt_q;
  gate_tgt_e    tgt_eff;
  logic [CW-1:0] cnt;
  // named internal events
  logic evt_change, timer_done, hs_wait, ls_wait, hs_arm, ls_arm, hs_nx, ls_nx;

  always_comb begin
    tgt_eff    = en_s ? target : TGT_OFF;
    evt_change = (tgt_eff != tgt_q);
    timer_done = (cnt == DEAD_W);
    hs_wait    = (tgt_eff == TGT_HS) && !hs_q && !ls_q && ls_off_s;
    ls_wait    = (tgt_eff == TGT_LS) && !ls_q && !hs_q && hs_off_s;
    hs_arm     = hs_wait && timer_done && !evt_change;
    ls_arm     = ls_wait && timer_done && !evt_change;
    hs_nx      = (tgt_eff == TGT_HS) && (hs_q || hs_arm);
    ls_nx      = (tgt_eff == TGT_LS) && (ls_q || ls_arm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_OFF;
      cnt   <= '0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      tgt_q <= tgt_eff;
      hs_q  <= hs_nx;
      ls_q  <= ls_nx;
      if (evt_change || !(hs_wait || ls_wait)) cnt <= '0;
      else if (!timer_done)                    cnt <= cnt + 1'b1;
    end
  end

  // R6: high side only turns on after low side is dropped and sensed off
  p_hs_after_ls_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> ($past(ls_off_s) && !$past(ls_q)));
  // R7: mirrored rule for the low side
  p_ls_after_hs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> ($past(hs_off_s) && !$past(hs_q)));
  // R8: a disabled cycle clears both gate registers
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!hs_q && !ls_q));
  // R9: forced low side keeps the high side off
  p_force_blocks_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (target == TGT_LS) |=> !hs_q);
  // R11: counter never runs past its limit
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEAD_W);
endmodule

// File: rtl/tlpwm_gate_seq.sv
module tlpwm_gate_seq
  import tlpwm_pkg::*;
#(
  parameter int DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic cmp_above_hi,
  input  logic cmp_above_lo,
  input  logic i_rev,
  input  logic force_ls,
  input  logic hs_off_sns,
  input  logic ls_off_sns,
  output logic hs_gate,
  output logic ls_gate
);
  logic [SI_NUM-1:0] raw_in;
  logic [SI_NUM-1:0] syn;
  pwm_lvl_e  lvl;
  gate_tgt_e target;
  logic      hs_q, ls_q;

  always_comb begin
    raw_in           = '0;
    raw_in[SI_HI]    = cmp_above_hi;
    raw_in[SI_LO]    = cmp_above_lo;
    raw_in[SI_REV]   = i_rev;
    raw_in[SI_FORCE] = force_ls;
    raw_in[SI_HSOFF] = hs_off_sns;
    raw_in[SI_LSOFF] = ls_off_sns;
    raw_in[SI_EN]    = chip_en;
  end

  tlpwm_sync #(.W(SI_NUM)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .d_sync  (syn)
  );

  tlpwm_decode u_dec (
    .above_hi  (syn[SI_HI]),
    .above_lo  (syn[SI_LO]),
    .rev       (syn[SI_REV]),
    .force_low (syn[SI_FORCE]),
    .lvl       (lvl),
    .target    (target)
  );

  tlpwm_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_s     (syn[SI_EN]),
    .target   (target),
    .hs_off_s (syn[SI_HSOFF]),
    .ls_off_s (syn[SI_LSOFF]),
    .hs_q     (hs_q),
    .ls_q     (ls_q)
  );

  // raw enable masks the outputs with no clock edge in between (R8)
  assign hs_gate = hs_q & chip_en;
  assign ls_gate = ls_q & chip_en;

  // R10: the two gates are never on together
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  // R1: a settled high level never drives the low side
  p_high_no_ls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_HIGH && !syn[SI_FORCE]) |=> !ls_q);
endmodule

// File: tb/tb_tlpwm_gate_seq.sv
module tb_tlpwm_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 6;
  localparam int SETTLE = 30;
  // vector: {hi, lo, rev, force, exp_hs, exp_ls}
  localparam logic [5:0] VEC [10] = '{
    6'b000001, 6'b110010, 6'b010001, 6'b011000, 6'b100001,
    6'b101000, 6'b111010, 6'b110101, 6'b011101, 6'b000001};

  logic clk = 1'b0, rst_n = 1'b0, chip_en = 1'b0;
  logic hi = 1'b0, lo = 1'b0, rev = 1'b0, frc = 1'b0;
  logic hs_stuck = 1'b0, ls_stuck = 1'b0;
  logic hs_gate, ls_gate, hs_off_sns, ls_off_sns;
  int total = 0, bad = 0, overlaps = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // off-sense follows the gate directly unless held stuck by the bench
  assign hs_off_sns = !hs_gate && !hs_stuck;
  assign ls_off_sns = !ls_gate && !ls_stuck;

  tlpwm_gate_seq #(.DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
    .cmp_above_hi(hi), .cmp_above_lo(lo), .i_rev(rev), .force_ls(frc),
    .hs_off_sns(hs_off_sns), .ls_off_sns(ls_off_sns),
    .hs_gate(hs_gate), .ls_gate(ls_gate));

  always @(negedge clk) if (rst_n && hs_gate && ls_gate) overlaps++;

  function automatic string vec_req(input int i);
    case (i)
      0, 9: return "R2";
      1, 6: return "R1";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts rising edges until the chosen gate is high, sampling at falling edges
  task automatic edges_until(input bit want_hs, input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk); @(negedge clk);
      if ((want_hs ? hs_gate : ls_gate) && n < 0) begin
        n = k;
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int hs_seen;
    repeat (3) @(negedge clk);
    check("reset", {30'd0, hs_gate, ls_gate}, 0);
    rst_n = 1'b1;
    chip_en = 1'b1;
    repeat (SETTLE) @(negedge clk);
    check("R2 start", {30'd0, hs_gate, ls_gate}, 1);

    // table walk
    for (int i = 0; i < 10; i++) begin
      {hi, lo, rev, frc} = VEC[i][5:2];
      repeat (SETTLE) @(negedge clk);
      check($sformatf("%s vec%0d", vec_req(i), i), {30'd0, hs_gate, ls_gate}, int'(VEC[i][1:0]));
    end

    // R6: rising edge timing, low side currently on
    {hi, lo, rev, frc} = 4'b1100;
    edges_until(1'b1, 40, n);
    check("R6 hs turn-on edge", n, 6 + DEAD);
    // R7: falling edge timing
    {hi, lo} = 2'b00;
    edges_until(1'b0, 40, n);
    check("R7 ls turn-on edge", n, 6 + DEAD);

    // R6: stuck low-side sense blocks high side
    ls_stuck = 1'b1;
    {hi, lo} = 2'b11;
    repeat (SETTLE) @(negedge clk);
    check("R6 blocked hs", {30'd0, hs_gate, ls_gate}, 0);
    ls_stuck = 1'b0;
    repeat (SETTLE) @(negedge clk);
    check("R6 released hs", {30'd0, hs_gate, ls_gate}, 2);

    // R8: immediate mask, then re-enable timing
    chip_en = 1'b0;
    #1;
    check("R8 immediate mask", {30'd0, hs_gate, ls_gate}, 0);
    repeat (SETTLE) @(negedge clk);
    check("R8 held off", {30'd0, hs_gate, ls_gate}, 0);
    chip_en = 1'b1;
    edges_until(1'b1, 40, n);
    check("R8 re-enable edge", n, 4 + DEAD);

    // R11: reversal before the high side arms restarts the count
    {hi, lo} = 2'b00;
    repeat (SETTLE) @(negedge clk);
    {hi, lo} = 2'b11;
    hs_seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); @(negedge clk);
      if (hs_gate) hs_seen = 1;
    end
    {hi, lo} = 2'b00;
    n = -1;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (hs_gate) hs_seen = 1;
      if (ls_gate) begin n = k; break; end
    end
    check("R11 hs never on", hs_seen, 0);
    check("R11 ls turn-on edge", n, 4 + DEAD);

    // R9: force during high level with reversed current
    {hi, lo, rev, frc} = 4'b1111;
    repeat (SETTLE) @(negedge clk);
    check("R9 force over high", {30'd0, hs_gate, ls_gate}, 1);
    frc = 1'b0;
    repeat (SETTLE) @(negedge clk);
    check("R1 after force", {30'd0, hs_gate, ls_gate}, 2);

    check("R10 overlap cycles", overlaps, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule